// File: doc/BRIEF.md
# Multi-Phase SPI Transaction Master

This block is an SPI master that runs one transaction per start pulse, framed by an active-low chip select. A transaction is a fixed chain of up to five segments. First comes an opcode segment of up to 16 bits, then an address segment of up to 32 bits, then an outbound payload of up to 512 bits taken from a transmit buffer. A turnaround gap of up to 256 idle clocks follows, and last an inbound payload of up to 512 bits written into a receive buffer. Each segment has its own length, and a length of zero removes that segment from the chain. Every field goes out most-significant bit first.

Settings are sampled when a start pulse is accepted. They cover the five lengths, the opcode and address values, the clock phase, a duplex flag and a clock divider. The serial clock idles low, and one full serial-clock period lasts the divider value in system clocks. With the duplex flag set, the inbound segment is dropped and MISO is captured while the outbound payload is shifted. A one-cycle completion pulse tells the host that the receive buffer holds the result.

Top module: `spi_phase_master`

## Requirements
- R1: Segments run in the order opcode, address, outbound payload, gap, inbound payload. A zero-length segment produces no serial-clock pulses, so the number of rising `sclk` edges equals the sum of the active lengths.
- R2: Bits leave MSB first. The opcode sends `op_val[op_len-1]` first and the address sends `adr_val[adr_len-1]` first. Outbound payload bit n (n=0 first) is `tx_buf[511-n]`. Inbound payload bit n lands in `rx_buf[511-n]`.
- R3: `mosi` is 1 during the gap segment, during the inbound segment and whenever no transaction is running.
- R4: The effective divider D is `clk_div`, except that 0 and 1 are used as 2. Each low half of `sclk` lasts D-D/2 system clocks and each high half lasts D/2. For B bits, `cs_n` stays low for (B+1)(D-D/2)+B(D/2) cycles.
- R5: With `cpha`=0 the master samples MISO on the rising `sclk` edge and moves `mosi` on the falling edge. With `cpha`=1 it moves `mosi` on the rising edge and samples on the falling edge. `sclk` is low whenever `cs_n` is high.
- R6: `cs_n` is high when idle. It goes low one low half-period before the first `sclk` edge and returns high one half-period after the last edge.
- R7: With `duplex`=1 the inbound segment is skipped whatever `rd_len` holds. MISO bit n of the outbound payload is stored in `rx_buf[511-n]`.
- R8: An accepted start clears `rx_buf` to zero. MISO is ignored during the opcode, address and gap segments, and during the outbound payload when `duplex`=0.
- R9: `busy` is high from the cycle after an accepted start until `cs_n` is back high. `done` is high for exactly one cycle, starting one clock after `cs_n` returns high.
- R10: A start pulse while `busy` is high is ignored. Settings changed on the inputs during a transaction do not affect it.
- R11: If every active length is zero, `cs_n` never goes low and `done` pulses two clocks after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction when idle |
| op_len | input | 5 | Opcode segment length, 0..16 bits |
| op_val | input | 16 | Opcode value, right aligned |
| adr_len | input | 6 | Address segment length, 0..32 bits |
| adr_val | input | 32 | Address value, right aligned |
| wr_len | input | 10 | Outbound payload length, 0..512 bits |
| gap_len | input | 9 | Gap length, 0..256 clocks |
| rd_len | input | 10 | Inbound payload length, 0..512 bits |
| duplex | input | 1 | Capture MISO during the outbound payload |
| cpha | input | 1 | Clock phase select |
| clk_div | input | 8 | System clocks per serial clock |
| tx_buf | input | 512 | Outbound payload, held stable while busy |
| miso | input | 1 | Serial data from the slave |
| rx_buf | output | 512 | Captured inbound data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the slave |

## Verification
The bench plays an SPI slave that records `mosi` and drives a known MISO pattern on the edges that fit the current phase. It then compares the recorded stream and the receive buffer against values it builds from the lengths. Odd dividers check the uneven half-periods: a design that splits them the wrong way gets the `cs_n` low time wrong. The full-duplex case leaves a nonzero `rd_len`, so a design that still runs the inbound segment produces extra clocks. A short case follows a duplex one to expose a receive buffer that is not cleared. A second start mid-transaction, with a changed opcode length, catches a design that restarts or samples settings late. A run with all lengths zero catches a design that asserts chip select for an empty frame.

// File: rtl/spi_phase_pkg.sv
package spi_phase_pkg;

  // Sizing of the segments and buffers
  localparam int OP_MAX    = 16;
  localparam int ADR_MAX   = 32;
  localparam int BUF_BITS  = 512;
  localparam int GAP_MAX   = 256;
  localparam int DIV_W     = 8;

  localparam int OP_LW     = $clog2(OP_MAX + 1);
  localparam int ADR_LW    = $clog2(ADR_MAX + 1);
  localparam int BUF_LW    = $clog2(BUF_BITS + 1);
  localparam int GAP_LW    = $clog2(GAP_MAX + 1);
  localparam int OP_AW     = $clog2(OP_MAX);
  localparam int ADR_AW    = $clog2(ADR_MAX);
  localparam int BUF_AW    = $clog2(BUF_BITS);
  localparam int TOT_MAX   = OP_MAX + ADR_MAX + BUF_BITS + GAP_MAX + BUF_BITS;
  localparam int IDX_W     = $clog2(TOT_MAX + 1);
  localparam int HALF_W    = IDX_W + 1;

  typedef enum logic [2:0] {
    SEG_NONE, SEG_OP, SEG_ADR, SEG_WR, SEG_GAP, SEG_RD
  } seg_e;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_CLOSE} seq_e;

  typedef struct packed {
    logic [OP_LW-1:0]   op_len;
    logic [OP_MAX-1:0]  op_val;
    logic [ADR_LW-1:0]  adr_len;
    logic [ADR_MAX-1:0] adr_val;
    logic [BUF_LW-1:0]  wr_len;
    logic [GAP_LW-1:0]  gap_len;
    logic [BUF_LW-1:0]  rd_len;
    logic               duplex;
    logic               cpha;
  } frame_cfg_t;

  typedef struct packed {
    seg_e             seg;
    logic [IDX_W-1:0] off;
  } slot_t;

  // Saturate lengths to their maxima; duplex removes the inbound segment
  function automatic frame_cfg_t clean_frame(frame_cfg_t r);
    frame_cfg_t c;
    c = r;
    if (r.op_len  > OP_LW'(OP_MAX))     c.op_len  = OP_LW'(OP_MAX);
    if (r.adr_len > ADR_LW'(ADR_MAX))   c.adr_len = ADR_LW'(ADR_MAX);
    if (r.wr_len  > BUF_LW'(BUF_BITS))  c.wr_len  = BUF_LW'(BUF_BITS);
    if (r.gap_len > GAP_LW'(GAP_MAX))   c.gap_len = GAP_LW'(GAP_MAX);
    if (r.rd_len  > BUF_LW'(BUF_BITS))  c.rd_len  = BUF_LW'(BUF_BITS);
    if (r.duplex)                       c.rd_len  = '0;
    return c;
  endfunction

  function automatic logic [DIV_W-1:0] eff_div(logic [DIV_W-1:0] d);
    return (d < DIV_W'(2)) ? DIV_W'(2) : d;
  endfunction

  // High halves are the shorter one when the divider is odd
  function automatic logic [DIV_W-1:0] half_len(logic [DIV_W-1:0] d, logic hi);
    return hi ? (d >> 1) : (d - (d >> 1));
  endfunction

  function automatic logic [IDX_W-1:0] total_bits(frame_cfg_t c);
    return IDX_W'(c.op_len) + IDX_W'(c.adr_len) + IDX_W'(c.wr_len)
         + IDX_W'(c.gap_len) + IDX_W'(c.rd_len);
  endfunction

  // Map a global bit index to its segment and the offset inside it
  function automatic slot_t locate(frame_cfg_t c, logic [IDX_W-1:0] k);
    logic [IDX_W-1:0] e_op, e_adr, e_wr, e_gap, e_rd;
    slot_t s;
    e_op  = IDX_W'(c.op_len);
    e_adr = e_op  + IDX_W'(c.adr_len);
    e_wr  = e_adr + IDX_W'(c.wr_len);
    e_gap = e_wr  + IDX_W'(c.gap_len);
    e_rd  = e_gap + IDX_W'(c.rd_len);
    s.seg = SEG_NONE;
    s.off = '0;
    if (k < e_op) begin
      s.seg = SEG_OP;  s.off = k;
    end else if (k < e_adr) begin
      s.seg = SEG_ADR; s.off = k - e_op;
    end else if (k < e_wr) begin
      s.seg = SEG_WR;  s.off = k - e_adr;
    end else if (k < e_gap) begin
      s.seg = SEG_GAP; s.off = k - e_wr;
    end else if (k < e_rd) begin
      s.seg = SEG_RD;  s.off = k - e_gap;
    end
    return s;
  endfunction

  // Outgoing bit for a slot, MSB of each field first
  function automatic logic pick_bit(frame_cfg_t c, slot_t s, logic [BUF_BITS-1:0] tx);
    logic [OP_AW-1:0]  oi;
    logic [ADR_AW-1:0] ai;
    logic [BUF_AW-1:0] ti;
    oi = OP_AW'(c.op_len - OP_LW'(1) - OP_LW'(s.off));
    ai = ADR_AW'(c.adr_len - ADR_LW'(1) - ADR_LW'(s.off));
    ti = BUF_AW'(BUF_BITS - 1) - BUF_AW'(s.off);
    case (s.seg)
      SEG_OP:  return c.op_val[oi];
      SEG_ADR: return c.adr_val[ai];
      SEG_WR:  return tx[ti];
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import spi_phase_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hi_half,
  input  logic [DIV_W-1:0] div_q,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] cur_len;

  assign cur_len = half_len(div_q, hi_half);
  assign tick    = run && (cnt == cur_len - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + DIV_W'(1);
  end

endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
  import spi_phase_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  frame_cfg_t        cfg_in,
  input  logic [DIV_W-1:0]  div_in,
  input  logic              tick,
  output frame_cfg_t        cfg_q,
  output logic [DIV_W-1:0]  div_q,
  output logic [HALF_W-1:0] half_idx,
  output logic [HALF_W-1:0] last_half,
  output logic              accept,
  output logic              run,
  output logic              busy,
  output logic              done
);

  seq_e             state;
  logic [IDX_W-1:0] bits_in;

  assign bits_in = total_bits(cfg_in);
  assign accept  = start && (state == ST_IDLE);
  assign run     = (state == ST_RUN);
  assign busy    = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cfg_q     <= '0;
      div_q     <= DIV_W'(2);
      half_idx  <= '0;
      last_half <= '0;
      done      <= 1'b0;
    end else begin
      done <= (state == ST_CLOSE);
      case (state)
        ST_IDLE: begin
          if (start) begin
            cfg_q     <= cfg_in;
            div_q     <= div_in;
            half_idx  <= '0;
            last_half <= {bits_in, 1'b0};
            state     <= (bits_in == '0) ? ST_CLOSE : ST_RUN;
          end
        end
        ST_RUN: begin
          if (tick) begin
            if (half_idx == last_half) state <= ST_CLOSE;
            else half_idx <= half_idx + HALF_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_bit_path.sv
module spi_bit_path
  import spi_phase_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  frame_cfg_t          cfg_q,
  input  logic                run,
  input  logic                tick,
  input  logic                clear,
  input  logic [HALF_W-1:0]   half_idx,
  input  logic [HALF_W-1:0]   last_half,
  input  logic [BUF_BITS-1:0] tx_buf,
  input  logic                miso,
  output logic                mosi,
  output logic [BUF_BITS-1:0] rx_buf,
  output logic                sample_evt,
  output seg_e                drv_seg
);

  logic [IDX_W-1:0]  drv_idx;
  logic [IDX_W-1:0]  smp_idx;
  slot_t             drv_slot;
  slot_t             smp_slot;
  logic              cap_en;
  logic [BUF_AW-1:0] cap_pos;

  // Shown bit: cpha=1 advances on the rising edge (odd half index)
  always_comb begin
    if (cfg_q.cpha)
      drv_idx = (half_idx == '0) ? '0 : IDX_W'((half_idx - HALF_W'(1)) >> 1);
    else
      drv_idx = IDX_W'(half_idx >> 1);
  end

  assign smp_idx  = IDX_W'(half_idx >> 1);
  assign drv_slot = locate(cfg_q, drv_idx);
  assign smp_slot = locate(cfg_q, smp_idx);
  assign drv_seg  = run ? drv_slot.seg : SEG_NONE;
  assign mosi     = run ? pick_bit(cfg_q, drv_slot, tx_buf) : 1'b1;

  // Sampling edge: end of a low half (cpha=0) or of a high half (cpha=1)
  assign sample_evt = run && tick &&
                      (cfg_q.cpha ? half_idx[0]
                                  : (!half_idx[0] && (half_idx != last_half)));

  assign cap_en  = sample_evt &&
                   ((smp_slot.seg == SEG_RD) ||
                    ((smp_slot.seg == SEG_WR) && cfg_q.duplex));
  assign cap_pos = BUF_AW'(BUF_BITS - 1) - BUF_AW'(smp_slot.off);

  for (genvar g = 0; g < BUF_BITS; g++) begin : g_rx
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   rx_buf[g] <= 1'b0;
      else if (clear)                               rx_buf[g] <= 1'b0;
      else if (cap_en && (cap_pos == BUF_AW'(g)))   rx_buf[g] <= miso;
    end
  end

endmodule

// File: rtl/spi_phase_master.sv
module spi_phase_master
  import spi_phase_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [OP_LW-1:0]    op_len,
  input  logic [OP_MAX-1:0]   op_val,
  input  logic [ADR_LW-1:0]   adr_len,
  input  logic [ADR_MAX-1:0]  adr_val,
  input  logic [BUF_LW-1:0]   wr_len,
  input  logic [GAP_LW-1:0]   gap_len,
  input  logic [BUF_LW-1:0]   rd_len,
  input  logic                duplex,
  input  logic                cpha,
  input  logic [DIV_W-1:0]    clk_div,
  input  logic [BUF_BITS-1:0] tx_buf,
  input  logic                miso,
  output logic [BUF_BITS-1:0] rx_buf,
  output logic                busy,
  output logic                done,
  output logic                sclk,
  output logic                cs_n,
  output logic                mosi
);

  frame_cfg_t        raw_cfg;
  frame_cfg_t        cfg_in;
  frame_cfg_t        cfg_q;
  logic [DIV_W-1:0]  div_in;
  logic [DIV_W-1:0]  div_q;
  logic [HALF_W-1:0] half_idx;
  logic [HALF_W-1:0] last_half;
  logic              accept;
  logic              run;
  logic              tick;
  logic              sample_evt;
  seg_e              drv_seg;

  always_comb begin
    raw_cfg.op_len  = op_len;
    raw_cfg.op_val  = op_val;
    raw_cfg.adr_len = adr_len;
    raw_cfg.adr_val = adr_val;
    raw_cfg.wr_len  = wr_len;
    raw_cfg.gap_len = gap_len;
    raw_cfg.rd_len  = rd_len;
    raw_cfg.duplex  = duplex;
    raw_cfg.cpha    = cpha;
  end

  assign cfg_in = clean_frame(raw_cfg);
  assign div_in = eff_div(clk_div);

  spi_frame_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cfg_in    (cfg_in),
    .div_in    (div_in),
    .tick      (tick),
    .cfg_q     (cfg_q),
    .div_q     (div_q),
    .half_idx  (half_idx),
    .last_half (last_half),
    .accept    (accept),
    .run       (run),
    .busy      (busy),
    .done      (done)
  );

  spi_sclk_gen u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .hi_half (half_idx[0]),
    .div_q   (div_q),
    .tick    (tick)
  );

  spi_bit_path u_bits (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_q      (cfg_q),
    .run        (run),
    .tick       (tick),
    .clear      (accept),
    .half_idx   (half_idx),
    .last_half  (last_half),
    .tx_buf     (tx_buf),
    .miso       (miso),
    .mosi       (mosi),
    .rx_buf     (rx_buf),
    .sample_evt (sample_evt),
    .drv_seg    (drv_seg)
  );

  assign sclk = run && half_idx[0];
  assign cs_n = !run;

endmodule

// File: rtl/spi_phase_master_chk.sv
module spi_phase_master_chk
  import spi_phase_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              sclk,
  input logic              cs_n,
  input logic              mosi,
  input logic              run,
  input logic              sample_evt,
  input seg_e              drv_seg,
  input logic [HALF_W-1:0] half_idx,
  input logic [HALF_W-1:0] last_half
);

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sclk && mosi));

  p_sclk_unframed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  p_pad_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && ((drv_seg == SEG_GAP) || (drv_seg == SEG_RD))) |-> mosi);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && cs_n && $past(busy) && $past(cs_n)));

  p_start_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(last_half));

  p_sample_framed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |-> !cs_n);

  p_half_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (half_idx <= last_half));

endmodule

bind spi_phase_master spi_phase_master_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .sclk       (sclk),
  .cs_n       (cs_n),
  .mosi       (mosi),
  .run        (run),
  .sample_evt (sample_evt),
  .drv_seg    (drv_seg),
  .half_idx   (half_idx),
  .last_half  (last_half)
);

// File: tb/tb_spi_phase_master.sv
module tb_spi_phase_master;

  typedef struct packed {
    logic [4:0]  ol;
    logic [15:0] ov;
    logic [5:0]  al;
    logic [31:0] av;
    logic [9:0]  wl;
    logic [8:0]  gl;
    logic [9:0]  rl;
    logic        dx;
    logic        cp;
    logic [7:0]  dv;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{5'd8,  16'h00A5, 6'd24, 32'h00123456, 10'd16,  9'd8,   10'd16,  1'b0, 1'b0, 8'd4},
    '{5'd8,  16'h003C, 6'd16, 32'h0000BEAD, 10'd12,  9'd3,   10'd9,   1'b0, 1'b1, 8'd5},
    '{5'd0,  16'h0000, 6'd0,  32'h00000000, 10'd0,   9'd0,   10'd32,  1'b0, 1'b0, 8'd2},
    '{5'd16, 16'hBEEF, 6'd0,  32'h00000000, 10'd0,   9'd4,   10'd8,   1'b0, 1'b1, 8'd3},
    '{5'd4,  16'h0009, 6'd8,  32'h0000005A, 10'd24,  9'd0,   10'd40,  1'b1, 1'b0, 8'd2},
    '{5'd0,  16'h0000, 6'd0,  32'h00000000, 10'd512, 9'd0,   10'd0,   1'b0, 1'b1, 8'd1},
    '{5'd0,  16'h0000, 6'd0,  32'h00000000, 10'd0,   9'd256, 10'd512, 1'b0, 1'b0, 8'd0},
    '{5'd16, 16'h8001, 6'd32, 32'hF00DCAFE, 10'd512, 9'd256, 10'd512, 1'b0, 1'b1, 8'd7}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [4:0]   op_len = '0;
  logic [15:0]  op_val = '0;
  logic [5:0]   adr_len = '0;
  logic [31:0]  adr_val = '0;
  logic [9:0]   wr_len = '0;
  logic [8:0]   gap_len = '0;
  logic [9:0]   rd_len = '0;
  logic         duplex = 1'b0;
  logic         cpha = 1'b0;
  logic [7:0]   clk_div = 8'd2;
  logic [511:0] tx_buf = '0;
  logic         miso = 1'b0;
  logic [511:0] rx_buf;
  logic         busy, done, sclk, cs_n, mosi;

  spi_phase_master dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .op_len(op_len), .op_val(op_val), .adr_len(adr_len), .adr_val(adr_val),
    .wr_len(wr_len), .gap_len(gap_len), .rd_len(rd_len), .duplex(duplex),
    .cpha(cpha), .clk_div(clk_div), .tx_buf(tx_buf), .miso(miso),
    .rx_buf(rx_buf), .busy(busy), .done(done), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic bit pat(input int k);
    return ((k % 7) == 0) || ((k % 3) == 1);
  endfunction

  // Slave model: records mosi, drives the miso pattern by bit index
  bit cap [0:1399];
  int scnt = 0;
  int mcnt = 0;
  logic sclk_seen = 1'b0;

  always @(negedge cs_n or posedge sclk or negedge sclk) begin
    if (sclk !== sclk_seen) begin
      sclk_seen = sclk;
      if (sclk === 1'b1) begin
        if (!cpha) begin if (scnt < 1400) cap[scnt] = mosi; scnt++; end
        else begin miso = pat(mcnt); mcnt++; end
      end else begin
        if (!cpha) begin miso = pat(mcnt); mcnt++; end
        else begin if (scnt < 1400) cap[scnt] = mosi; scnt++; end
      end
    end else if (cs_n === 1'b0) begin
      scnt = 0;
      mcnt = 0;
      if (!cpha) begin miso = pat(0); mcnt = 1; end
    end
  end

  bit           exp_bits [0:1399];
  logic [511:0] exp_rx;
  int           exp_n;

  task automatic build_expected(input vec_t v);
    int k;
    int ol, al, wl, gl, rl;
    ol = (v.ol > 16) ? 16 : int'(v.ol);
    al = (v.al > 32) ? 32 : int'(v.al);
    wl = (v.wl > 512) ? 512 : int'(v.wl);
    gl = (v.gl > 256) ? 256 : int'(v.gl);
    rl = v.dx ? 0 : ((v.rl > 512) ? 512 : int'(v.rl));
    k = 0;
    exp_rx = '0;
    for (int i = ol - 1; i >= 0; i--) begin exp_bits[k] = v.ov[i]; k++; end
    for (int i = al - 1; i >= 0; i--) begin exp_bits[k] = v.av[i]; k++; end
    for (int i = 0; i < wl; i++) begin
      exp_bits[k] = tx_buf[511 - i];
      if (v.dx) exp_rx[511 - i] = pat(k);
      k++;
    end
    for (int i = 0; i < gl; i++) begin exp_bits[k] = 1'b1; k++; end
    for (int i = 0; i < rl; i++) begin
      exp_bits[k] = 1'b1;
      exp_rx[511 - i] = pat(k);
      k++;
    end
    exp_n = k;
  endtask

  task automatic load(input vec_t v, input int vi);
    op_len = v.ol; op_val = v.ov; adr_len = v.al; adr_val = v.av;
    wr_len = v.wl; gap_len = v.gl; rd_len = v.rl; duplex = v.dx;
    cpha = v.cp; clk_div = v.dv;
    for (int i = 0; i < 512; i++) tx_buf[i] = (((i * 13) + (vi * 5)) % 11) < 5;
  endtask

  // Run one transaction; optionally fire a second start mid-run
  task automatic run_txn(input vec_t v, input int vi, input bit extra);
    int low_cyc, wait_cyc, d, lo, hi, exp_low, bad, first_bad;
    logic cs_h1, cs_h2;
    build_expected(v);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, $sformatf("R9 busy after start v%0d", vi), busy, 1);
    low_cyc = (cs_n === 1'b0) ? 1 : 0;
    cs_h1 = cs_n; cs_h2 = 1'b1;
    wait_cyc = 0;
    while (done !== 1'b1 && wait_cyc < 20000) begin
      if (extra && wait_cyc == 20) begin start = 1'b1; op_len = 5'd0; end
      if (extra && wait_cyc == 21) begin start = 1'b0; op_len = v.ol; end
      @(negedge clk);
      wait_cyc++;
      if (done !== 1'b1) begin
        if (cs_n === 1'b0) low_cyc++;
        cs_h2 = cs_h1; cs_h1 = cs_n;
      end
    end
    check(cs_h1 === 1'b1 && cs_h2 === 1'b0,
          $sformatf("R9 done one clock after cs_n rise v%0d", vi), {cs_h2, cs_h1}, 2'b01);
    d  = (v.dv < 2) ? 2 : int'(v.dv);
    hi = d / 2;
    lo = d - hi;
    exp_low = (exp_n + 1) * lo + exp_n * hi;
    check(low_cyc == exp_low, $sformatf("R4 R6 cs_n low cycles v%0d", vi), low_cyc, exp_low);
    check(scnt == exp_n, $sformatf("R1 R7 sclk bit count v%0d", vi), scnt, exp_n);
    bad = 0; first_bad = -1;
    for (int i = 0; i < exp_n && i < 1400; i++)
      if (cap[i] !== exp_bits[i]) begin bad++; if (first_bad < 0) first_bad = i; end
    check(bad == 0, $sformatf("R1 R2 R3 R5 mosi stream v%0d first bad bit %0d", vi, first_bad),
          (first_bad < 0) ? 0 : cap[first_bad], (first_bad < 0) ? 0 : exp_bits[first_bad]);
    bad = 0; first_bad = -1;
    for (int i = 0; i < 512; i++)
      if (rx_buf[i] !== exp_rx[i]) begin bad++; if (first_bad < 0) first_bad = i; end
    check(bad == 0, $sformatf("R2 R7 R8 rx_buf v%0d first bad pos %0d", vi, first_bad),
          (first_bad < 0) ? 0 : rx_buf[first_bad], (first_bad < 0) ? 0 : exp_rx[first_bad]);
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, $sformatf("R9 done width v%0d", vi), done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n === 1'b1 && sclk === 1'b0, "R6 reset cs_n/sclk", {cs_n, sclk}, 2'b10);
    check(mosi === 1'b1, "R3 reset mosi idle", mosi, 1);
    check(busy === 1'b0 && done === 1'b0, "R9 reset busy/done", {busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rx_buf === '0, "R8 reset rx_buf", rx_buf[511:448], 0);

    for (int vi = 0; vi < NV; vi++) begin
      load(VECS[vi], vi);
      run_txn(VECS[vi], vi, 1'b0);
    end

    // R10: second start mid-run with changed opcode length is ignored
    load(VECS[0], 0);
    run_txn(VECS[0], 0, 1'b1);

    // R11: empty frame
    begin
      int lows, done_at;
      op_len = '0; adr_len = '0; wr_len = '0; gap_len = '0; rd_len = '0; duplex = 1'b0;
      lows = 0; done_at = -1;
      @(negedge clk);
      start = 1'b1;
      for (int i = 1; i <= 4; i++) begin
        @(negedge clk);
        start = 1'b0;
        if (cs_n !== 1'b1) lows++;
        if (done === 1'b1 && done_at < 0) done_at = i;
      end
      check(lows == 0, "R11 empty frame keeps cs_n high", lows, 0);
      check(done_at == 2, "R11 empty frame done timing", done_at, 2);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule